// File: doc/BRIEF.md
# Output Driver Strength Calibration Sequencer

This block keeps track of the strength code that sets an output driver's impedance. An external comparator reports whether the drivers should get stronger or weaker. At a fixed interval the block looks at that report and moves an internal working code by no more than one step. The working code reaches the drivers only in cycles where the outputs are not driving, which covers write cycles, deselected cycles and cycles with the output enable off. That way the impedance never changes while data is on the bus.

A strap input covers boards where the reference pin is wired straight to a supply rail. While the strap is set, the block outputs a fixed minimum-impedance code and calibration stops. A status output tells the rest of the chip when enough non-driving cycles have passed since reset for the calibrated code to be trusted.

Top module: `drv_imp_cal`

## Requirements
- R1: An evaluation takes place once every EVAL_PERIOD (32) clock edges after reset is released, on edges 32, 64, 96 and so on. The working code changes only on those edges.
- R2: At an evaluation, the code rises by one when only `cmp_up_i` is high and falls by one when only `cmp_dn_i` is high. When both or neither are high, the code holds.
- R3: The 6-bit working code saturates at 63 and at 0 and never wraps around.
- R4: The code driven to the pads (`code_o`, with the strap clear) takes the working code only on clock edges where `drive_i` is low. A step made at evaluation edge N therefore shows at edge N+1 if that edge is non-driving.
- R5: If evaluations finish while `drive_i` stays high, `code_o` keeps its old value. At the first following edge with `drive_i` low, it takes the latest working code in a single update.
- R6: While `strap_min_i` is high, `code_o` is 63 (minimum impedance) with no clock delay, and the working code is frozen. When the strap is released, `code_o` returns to the code held before the strap was set.
- R7: `settled_o` rises after SETTLE_CYCLES (1024) clock edges with `drive_i` low. These edges need not be consecutive, and driving edges neither count toward the total nor reset it.
- R8: Once high, `settled_o` stays high until the next reset, whatever `drive_i` does.
- R9: During and just after reset, `code_o` is 32 (mid-scale) and `settled_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_up_i | input | 1 | Comparator asks for a stronger driver (higher code) |
| cmp_dn_i | input | 1 | Comparator asks for a weaker driver (lower code) |
| drive_i | input | 1 | Outputs are driving in this cycle (read with output enabled) |
| strap_min_i | input | 1 | Reference pin tied to a rail: force minimum-impedance code |
| code_o | output | 6 | Strength code applied to the output drivers |
| settled_o | output | 1 | Enough non-driving cycles seen since reset |

## Verification
If the interval timer is wrong, the step shows up on `code_o` on the wrong edge. A check one edge before and one edge after the expected update exposes it within the first 33 cycles. A wrong apply gate shows in two ways: `code_o` either moves during a long run of driving cycles, or it fails to catch up on the first non-driving edge. A miscounted settle counter moves the rise of `settled_o` off edge 1024, which the bench brackets at edges 1023 and 1024. Saturation faults surface as a wrap to the opposite end after about 1000 cycles of one-sided comparator input.

// File: rtl/imp_cal_pkg.sv
`timescale 1ns/1ps
package imp_cal_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  function automatic step_e decode_step(input logic up, input logic dn);
    if (up && !dn)      return STEP_UP;
    else if (dn && !up) return STEP_DN;
    else                return STEP_HOLD;
  endfunction
endpackage

// File: rtl/imp_cal_timer.sv
`timescale 1ns/1ps
module imp_cal_timer #(
  parameter int EVAL_PERIOD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = $clog2(EVAL_PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/imp_cal_stepper.sv
`timescale 1ns/1ps
module imp_cal_stepper
  import imp_cal_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(1 << (CODE_W - 1))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              strap_i,
  input  logic              cmp_up_i,
  input  logic              cmp_dn_i,
  output logic [CODE_W-1:0] work_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] work_q;
  step_e             step;

  assign step = decode_step(cmp_up_i, cmp_dn_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= RESET_CODE;
    end else if (tick_i && !strap_i) begin
      unique case (step)
        STEP_UP: if (work_q != CODE_MAX) work_q <= work_q + 1'b1;
        STEP_DN: if (work_q != '0)       work_q <= work_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign work_o = work_q;

  // Widened compare so a wrap 0<->max is not mistaken for a single step.
  assert_one_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(work_q) |->
      ({1'b0, work_q} == {1'b0, $past(work_q)} + 1'b1) ||
      ({1'b0, work_q} + 1'b1 == {1'b0, $past(work_q)}));

  assert_step_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(work_q) |-> $past(tick_i));

  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(work_q) == CODE_MAX) |-> (work_q != '0));

  assert_frozen_strap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(strap_i) |-> $stable(work_q));
endmodule

// File: rtl/imp_cal_apply.sv
`timescale 1ns/1ps
module imp_cal_apply #(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(1 << (CODE_W - 1))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drive_i,
  input  logic [CODE_W-1:0] work_i,
  output logic [CODE_W-1:0] applied_o
);
  logic [CODE_W-1:0] applied_q;

  // A pending step is simply the gap between work_i and applied_q.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       applied_q <= RESET_CODE;
    else if (!drive_i) applied_q <= work_i;
  end

  assign applied_o = applied_q;

  assert_apply_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(applied_q) |-> !$past(drive_i));

  assert_catch_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_i |=> (applied_q == $past(work_i)));
endmodule

// File: rtl/imp_cal_settle.sv
`timescale 1ns/1ps
module imp_cal_settle #(
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_i,
  output logic settled_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             settled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      settled_q <= 1'b0;
    end else if (!drive_i && !settled_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) settled_q <= 1'b1;
    end
  end

  assign settled_o = settled_q;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled_q |=> settled_q);

  assert_rise_on_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settled_q) |-> !$past(drive_i));
endmodule

// File: rtl/drv_imp_cal.sv
`timescale 1ns/1ps
module drv_imp_cal #(
  parameter int CODE_W        = 6,
  parameter int EVAL_PERIOD   = 32,
  parameter int SETTLE_CYCLES = 1024,
  parameter logic [CODE_W-1:0] RESET_CODE   = CODE_W'(1 << (CODE_W - 1)),
  parameter logic [CODE_W-1:0] MIN_IMP_CODE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_up_i,
  input  logic              cmp_dn_i,
  input  logic              drive_i,
  input  logic              strap_min_i,
  output logic [CODE_W-1:0] code_o,
  output logic              settled_o
);
  logic              tick;
  logic [CODE_W-1:0] work;
  logic [CODE_W-1:0] applied;

  imp_cal_timer #(.EVAL_PERIOD(EVAL_PERIOD)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  imp_cal_stepper #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_stepper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .strap_i (strap_min_i),
    .cmp_up_i(cmp_up_i),
    .cmp_dn_i(cmp_dn_i),
    .work_o  (work)
  );

  imp_cal_apply #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_apply (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drive_i  (drive_i),
    .work_i   (work),
    .applied_o(applied)
  );

  imp_cal_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drive_i  (drive_i),
    .settled_o(settled_o)
  );

  assign code_o = strap_min_i ? MIN_IMP_CODE : applied;

  assert_strap_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_min_i |-> (code_o == MIN_IMP_CODE));
endmodule

// File: tb/drv_imp_cal_test.sv
`timescale 1ns/1ps
module drv_imp_cal_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmp_up_i = 1'b0;
  logic       cmp_dn_i = 1'b0;
  logic       drive_i = 1'b0;
  logic       strap_min_i = 1'b0;
  logic [5:0] code_o;
  logic       settled_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  drv_imp_cal uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmp_up_i   (cmp_up_i),
    .cmp_dn_i   (cmp_dn_i),
    .drive_i    (drive_i),
    .strap_min_i(strap_min_i),
    .code_o     (code_o),
    .settled_o  (settled_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Leaves the bench at a negedge just after reset release; edge 1 is next.
  task automatic do_reset(input logic up, input logic dn, input logic drv, input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    cmp_up_i = up; cmp_dn_i = dn; drive_i = drv; strap_min_i = strap;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset_R9;
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 code after reset", code_o, 32);
    chk("R9 settled after reset", settled_o, 0);
  endtask

  task automatic t_rate_R1;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    edges(32);
    chk("R1 no update before edge 33", code_o, 32);
    edges(1);
    chk("R1/R4 first step at edge 33", code_o, 33);
    edges(31);
    chk("R1 no second step before edge 65", code_o, 33);
    edges(1);
    chk("R1/R2 second step at edge 65", code_o, 34);
  endtask

  task automatic t_dir_R2;
    do_reset(1'b0, 1'b1, 1'b0, 1'b0);
    edges(33);
    chk("R2 down step", code_o, 31);
    cmp_up_i = 1'b1; cmp_dn_i = 1'b1;
    edges(96);
    chk("R2 both high holds", code_o, 31);
    cmp_up_i = 1'b0; cmp_dn_i = 1'b0;
    edges(96);
    chk("R2 neither high holds", code_o, 31);
  endtask

  task automatic t_sat_R3;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    edges(32 * 45);
    chk("R3 saturates at top", code_o, 63);
    do_reset(1'b0, 1'b1, 1'b0, 1'b0);
    edges(32 * 45);
    chk("R3 saturates at bottom", code_o, 0);
  endtask

  task automatic t_pending_R5;
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    edges(100);
    chk("R4 held while driving", code_o, 32);
    cmp_up_i = 1'b0;
    drive_i = 1'b0;
    edges(1);
    chk("R5 pending applied on first hiz edge", code_o, 35);
  endtask

  task automatic t_strap_R6;
    do_reset(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 strap code right after reset", code_o, 63);
    edges(70);
    chk("R6 strap code holds", code_o, 63);
    strap_min_i = 1'b0;
    cmp_up_i = 1'b0;
    #0.1;
    chk("R6 frozen code back after strap", code_o, 32);
  endtask

  task automatic t_settle_R7;
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    edges(1023);
    chk("R7 not settled at 1023", settled_o, 0);
    edges(1);
    chk("R7 settled at 1024", settled_o, 1);
    drive_i = 1'b1;
    edges(200);
    chk("R8 sticky while driving", settled_o, 1);
    // split count
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    edges(512);
    drive_i = 1'b1;
    edges(300);
    drive_i = 1'b0;
    edges(511);
    chk("R7 reads do not count or clear", settled_o, 0);
    edges(1);
    chk("R7 settled after split count", settled_o, 1);
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    edges(1500);
    chk("R7 driving edges never settle", settled_o, 0);
  endtask

  initial begin
    t_reset_R9();
    t_rate_R1();
    t_dir_R2();
    t_sat_R3();
    t_pending_R5();
    t_strap_R6();
    t_settle_R7();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule